// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous 16-bit NOR flash bus. It turns a single request into the complete bus activity for one write operation. A request carries an operation code, a word address and a data word. The sequencer drives the chip-enable, write-enable and output-enable strobes, the address and the outgoing data. It emits the unlock-prefixed command writes, and the pulse widths of those writes are set by parameters. It then reads the target location repeatedly until the status toggle bit stops changing.

The result comes back as a one-cycle completion pulse, and an error flag is valid alongside it. If the device stays busy past the per-operation limit, the sequencer writes the read-mode reset command once and then reports the error. All durations are clock-cycle counts given as parameters. A simulation can therefore shrink the millisecond erase limits to a few hundred cycles.

Top module: `nor_flash_seq`

## Requirements
- R1: Opcode 0 (word program) produces exactly four bus writes, in this order: 00AAh to 555h, 0055h to 2AAh, 00A0h to 555h, then the request data to the request address.
- R2: Opcodes 1 (sector erase), 2 (block erase) and 3 (chip erase) produce exactly six writes: 00AAh@555h, 0055h@2AAh, 0080h@555h, 00AAh@555h, 0055h@2AAh, then a final write. The final write is 0050h to the address with its low SECT_AW bits cleared, 0030h to the address with its low BLK_AW bits cleared, or 0010h to 555h, respectively.
- R3: During a write, chip-enable is low and the address and data are stable and driven. Write-enable falls at least one cycle after the address is presented. It stays low exactly WE_LOW_CYC cycles and stays high at least WE_HIGH_CYC cycles between pulses. The data driver is never enabled while output-enable is low.
- R4: After the last command write, the sequencer polls with read cycles at the polled address. That is the request address for opcodes 0 and 3, and the masked sector or block address for opcodes 1 and 2.
- R5: Completion requires bit 6 to hold the same value on four consecutive reads: one equal pair followed by two confirming reads. A change of bit 6 during the confirming reads restarts the count.
- R6: The timeout counts clock cycles from the end of the last command write. The limit is TO_PROG_CYC for opcode 0, TO_ERASE_CYC for opcodes 1 and 2, and TO_CHIP_CYC for opcode 3.
- R7: On timeout, exactly one additional write of 00F0h to address 0 is issued, followed by the completion pulse.
- R8: The completion output is a one-cycle pulse. The error output is high only together with it: high after a timeout and low after a normal completion.
- R9: The ready output is high only when no operation is in progress. A request presented while ready is low is ignored.
- R10: After reset, chip-enable, write-enable and output-enable are high, the data driver is off, ready is high and completion is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_op_i | input | 2 | Opcode: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr_i | input | AW | Word address |
| req_data_i | input | 16 | Program data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error, valid with done_o |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | 16 | Outgoing data |
| flash_dq_oe_o | output | 1 | Data driver enable |
| flash_dq_i | input | 16 | Incoming data |

## Verification
The assertions assume three things about the environment. Reset is applied before the first request. The request fields may change freely, because they are sampled only on acceptance. The flash returns a settled word by the last cycle of each read.

The bench's flash model changes its read word only on the falling edge of output-enable and drives zero whenever output-enable is high. Requests are changed only on falling clock edges. Bit-6 patterns are generated from the read index, so the expected number of polling reads follows directly from the four-equal rule.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_WSET,
    BUS_WLOW,
    BUS_WHIGH,
    BUS_RD
  } bus_st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_POLL,
    S_ABORT,
    S_FIN
  } seq_st_e;

  localparam logic [10:0] UNLK_HI = 11'h555;
  localparam logic [10:0] UNLK_LO = 11'h2AA;
  localparam logic [7:0]  CODE_AA = 8'hAA;
  localparam logic [7:0]  CODE_55 = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERSET = 8'h80;
  localparam logic [7:0]  CODE_SECT  = 8'h50;
  localparam logic [7:0]  CODE_BLK   = 8'h30;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_RESET = 8'hF0;
endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int AW      = 22,
  parameter int SECT_AW = 11,
  parameter int BLK_AW  = 15
) (
  input  op_e             op_i,
  input  logic [2:0]      step_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     data_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [15:0]     wr_data_o,
  output logic            last_o,
  output logic [AW-1:0]   poll_addr_o
);
  localparam logic [AW-1:0] A_HI = AW'(UNLK_HI);
  localparam logic [AW-1:0] A_LO = AW'(UNLK_LO);

  logic [AW-1:0] sect_base, blk_base, fin_addr;
  logic [7:0]    fin_code;

  assign sect_base = {addr_i[AW-1:SECT_AW], {SECT_AW{1'b0}}};
  assign blk_base  = {addr_i[AW-1:BLK_AW], {BLK_AW{1'b0}}};

  always_comb begin
    case (op_i)
      OP_SECT: begin fin_addr = sect_base; fin_code = CODE_SECT; poll_addr_o = sect_base; end
      OP_BLK:  begin fin_addr = blk_base;  fin_code = CODE_BLK;  poll_addr_o = blk_base;  end
      default: begin fin_addr = A_HI;      fin_code = CODE_CHIP; poll_addr_o = addr_i;    end
    endcase
  end

  always_comb begin
    wr_addr_o = A_HI;
    wr_data_o = {8'h00, CODE_AA};
    if (op_i == OP_PROG) begin
      last_o = (step_i == 3'd3);
      case (step_i)
        3'd0:    begin wr_addr_o = A_HI; wr_data_o = {8'h00, CODE_AA};   end
        3'd1:    begin wr_addr_o = A_LO; wr_data_o = {8'h00, CODE_55};   end
        3'd2:    begin wr_addr_o = A_HI; wr_data_o = {8'h00, CODE_PROG}; end
        default: begin wr_addr_o = addr_i; wr_data_o = data_i;          end
      endcase
    end else begin
      last_o = (step_i == 3'd5);
      case (step_i)
        3'd0:    begin wr_addr_o = A_HI; wr_data_o = {8'h00, CODE_AA};    end
        3'd1:    begin wr_addr_o = A_LO; wr_data_o = {8'h00, CODE_55};    end
        3'd2:    begin wr_addr_o = A_HI; wr_data_o = {8'h00, CODE_ERSET}; end
        3'd3:    begin wr_addr_o = A_HI; wr_data_o = {8'h00, CODE_AA};    end
        3'd4:    begin wr_addr_o = A_LO; wr_data_o = {8'h00, CODE_55};    end
        default: begin wr_addr_o = fin_addr; wr_data_o = {8'h00, fin_code}; end
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_bus.sv
module flash_seq_bus
  import flash_seq_pkg::*;
#(
  parameter int AW          = 22,
  parameter int WE_LOW_CYC  = 3,
  parameter int WE_HIGH_CYC = 2,
  parameter int RD_CYC      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic [15:0]   dq_i,
  output logic          done_o,
  output logic [15:0]   rdata_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   dq_o,
  output logic          dq_oe_o
);
  localparam int MAX_WH = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAXC   = (MAX_WH > RD_CYC) ? MAX_WH : RD_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      addr_o  <= '0;
      dq_o    <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        BUS_IDLE: if (start_i) begin
          addr_o <= addr_i;
          dq_o   <= wdata_i;
          st_q   <= wr_i ? BUS_WSET : BUS_RD;
          cnt_q  <= CW'(RD_CYC - 1);
        end
        BUS_WSET: begin  // address setup before the falling edge
          st_q  <= BUS_WLOW;
          cnt_q <= CW'(WE_LOW_CYC - 1);
        end
        BUS_WLOW: if (cnt_q == '0) begin
          st_q  <= BUS_WHIGH;
          cnt_q <= CW'(WE_HIGH_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        BUS_WHIGH: if (cnt_q == '0) begin
          st_q   <= BUS_IDLE;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        BUS_RD: if (cnt_q == '0) begin
          rdata_o <= dq_i;
          st_q    <= BUS_IDLE;
          done_o  <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign ce_no   = (st_q == BUS_IDLE);
  assign we_no   = (st_q != BUS_WLOW);
  assign oe_no   = (st_q != BUS_RD);
  assign dq_oe_o = (st_q == BUS_WSET) || (st_q == BUS_WLOW) || (st_q == BUS_WHIGH);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(addr_o) && $stable(dq_o)));
  assert_we_needs_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> (!ce_no && $past(!ce_no)));
  assert_no_contention_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!dq_oe_o && we_no));
  assert_start_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ce_no);
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW           = 22,
  parameter int SECT_AW      = 11,
  parameter int BLK_AW       = 15,
  parameter int WE_LOW_CYC   = 3,
  parameter int WE_HIGH_CYC  = 2,
  parameter int RD_CYC       = 4,
  parameter int TO_PROG_CYC  = 500,
  parameter int TO_ERASE_CYC = 1250000,
  parameter int TO_CHIP_CYC  = 2500000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no,
  output logic [AW-1:0] flash_addr_o,
  output logic [15:0]   flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [15:0]   flash_dq_i
);
  localparam int TMAX1 = (TO_PROG_CYC > TO_ERASE_CYC) ? TO_PROG_CYC : TO_ERASE_CYC;
  localparam int TMAX  = (TMAX1 > TO_CHIP_CYC) ? TMAX1 : TO_CHIP_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  seq_st_e       state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [2:0]    step_q;
  logic          pend_q, err_q;
  logic          have_prev_q, prev_q;
  logic [1:0]    stable_q;
  logic [TW-1:0] tmo_cnt_q, lim_m1;
  logic          tmo_hit_q, tmo_now;

  logic [AW-1:0] cmd_addr, poll_addr, bus_addr;
  logic [15:0]   cmd_data, bus_wdata, rd_word;
  logic          cmd_last, bus_start, bus_wr, bus_done, tog;

  flash_seq_cmd #(.AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)) u_cmd (
    .op_i        (op_q),
    .step_i      (step_q),
    .addr_i      (addr_q),
    .data_i      (data_q),
    .wr_addr_o   (cmd_addr),
    .wr_data_o   (cmd_data),
    .last_o      (cmd_last),
    .poll_addr_o (poll_addr)
  );

  flash_seq_bus #(.AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
                  .RD_CYC(RD_CYC)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_start),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .dq_i    (flash_dq_i),
    .done_o  (bus_done),
    .rdata_o (rd_word),
    .ce_no   (flash_ce_no),
    .we_no   (flash_we_no),
    .oe_no   (flash_oe_no),
    .addr_o  (flash_addr_o),
    .dq_o    (flash_dq_o),
    .dq_oe_o (flash_dq_oe_o)
  );

  always_comb begin
    case (op_q)
      OP_PROG: lim_m1 = TW'(TO_PROG_CYC - 1);
      OP_CHIP: lim_m1 = TW'(TO_CHIP_CYC - 1);
      default: lim_m1 = TW'(TO_ERASE_CYC - 1);
    endcase
  end

  assign tmo_now   = tmo_hit_q || (tmo_cnt_q == lim_m1);
  assign tog       = rd_word[6];
  assign bus_start = !pend_q && (state_q == S_CMD || state_q == S_POLL || state_q == S_ABORT);
  assign bus_wr    = (state_q != S_POLL);
  assign bus_addr  = (state_q == S_CMD) ? cmd_addr : (state_q == S_POLL) ? poll_addr : '0;
  assign bus_wdata = (state_q == S_ABORT) ? {8'h00, CODE_RESET} : cmd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      pend_q      <= 1'b0;
      err_q       <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
      stable_q    <= '0;
      tmo_cnt_q   <= '0;
      tmo_hit_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          step_q  <= '0;
          err_q   <= 1'b0;
          pend_q  <= 1'b0;
          state_q <= S_CMD;
        end
        S_CMD: begin
          if (!pend_q) pend_q <= 1'b1;
          else if (bus_done) begin
            pend_q <= 1'b0;
            if (cmd_last) begin
              state_q     <= S_POLL;
              have_prev_q <= 1'b0;
              stable_q    <= '0;
              tmo_cnt_q   <= '0;
              tmo_hit_q   <= 1'b0;
            end else step_q <= step_q + 3'd1;
          end
        end
        S_POLL: begin
          if (!tmo_hit_q) begin
            if (tmo_cnt_q == lim_m1) tmo_hit_q <= 1'b1;
            else tmo_cnt_q <= tmo_cnt_q + 1'b1;
          end
          if (!pend_q) pend_q <= 1'b1;
          else if (bus_done) begin
            pend_q      <= 1'b0;
            prev_q      <= tog;
            have_prev_q <= 1'b1;
            if (have_prev_q && tog == prev_q) begin
              // equal pair plus two confirming reads
              if (stable_q == 2'd2) state_q <= S_FIN;
              else begin
                stable_q <= stable_q + 2'd1;
                if (tmo_now) state_q <= S_ABORT;
              end
            end else begin
              stable_q <= '0;
              if (tmo_now) state_q <= S_ABORT;
            end
          end
        end
        S_ABORT: begin
          if (!pend_q) pend_q <= 1'b1;
          else if (bus_done) begin
            pend_q  <= 1'b0;
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign err_o       = done_o && err_q;

  assert_accept_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_idle_bus_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (flash_ce_no && flash_we_no && flash_oe_no));
endmodule

// File: tb/tb_nor_flash_seq.sv
module tb_nor_flash_seq;
  localparam int AW = 22;
  localparam int WL = 3, WH = 2, RDC = 4;
  localparam int TOP = 300, TOE = 500, TOC = 700;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req_valid, req_ready, done, err;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_data;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [15:0]   f_dq_o, f_dq_i;

  nor_flash_seq #(.AW(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .RD_CYC(RDC),
                  .TO_PROG_CYC(TOP), .TO_ERASE_CYC(TOE), .TO_CHIP_CYC(TOC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .err_o(err), .flash_ce_no(ce_n), .flash_we_no(we_n),
    .flash_oe_no(oe_n), .flash_addr_o(f_addr), .flash_dq_o(f_dq_o),
    .flash_dq_oe_o(dq_oe), .flash_dq_i(f_dq_i));

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // flash model
  int mode = 0, kpar = 0, rd_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] wa [0:15];
  logic [15:0]   wd [0:15];
  time           wt [0:15];
  logic [AW-1:0] last_rd_addr;
  logic [15:0]   rd_word = 16'h0;
  time t_fall = 0, t_rise = 0, low_min = 1e9, low_max = 0, high_min = 1e9;

  function automatic logic b6_at(int i);
    case (mode)
      0: return (i < kpar) ? logic'(i & 1) : logic'(kpar & 1);
      1: return (i == kpar);
      default: return logic'(i & 1);
    endcase
  endfunction

  always @(negedge oe_n) begin
    rd_word = 16'hA5A5;
    rd_word[6] = b6_at(rd_cnt);
    last_rd_addr = f_addr;
    rd_cnt++;
  end
  assign f_dq_i = oe_n ? 16'h0000 : rd_word;

  always @(negedge we_n) begin
    t_fall = $time;
    if (wr_cnt > 0 && ($time - t_rise) < high_min) high_min = $time - t_rise;
  end
  always @(posedge we_n) if (!ce_n) begin
    t_rise = $time;
    if ($time - t_fall < low_min) low_min = $time - t_fall;
    if ($time - t_fall > low_max) low_max = $time - t_fall;
    if (wr_cnt < 16) begin
      wa[wr_cnt] = f_addr; wd[wr_cnt] = f_dq_o; wt[wr_cnt] = $time;
    end
    wr_cnt++;
  end

  function automatic void exp_wr(input int op, input int i, input logic [AW-1:0] a,
                                 input logic [15:0] d, output logic [AW-1:0] ea,
                                 output logic [15:0] ed);
    if (op == 0) begin
      case (i)
        0: begin ea = 22'h555; ed = 16'h00AA; end
        1: begin ea = 22'h2AA; ed = 16'h0055; end
        2: begin ea = 22'h555; ed = 16'h00A0; end
        default: begin ea = a; ed = d; end
      endcase
    end else begin
      case (i)
        0: begin ea = 22'h555; ed = 16'h00AA; end
        1: begin ea = 22'h2AA; ed = 16'h0055; end
        2: begin ea = 22'h555; ed = 16'h0080; end
        3: begin ea = 22'h555; ed = 16'h00AA; end
        4: begin ea = 22'h2AA; ed = 16'h0055; end
        default: case (op)
          1: begin ea = a & ~22'h7FF;  ed = 16'h0050; end
          2: begin ea = a & ~22'h7FFF; ed = 16'h0030; end
          default: begin ea = 22'h555; ed = 16'h0010; end
        endcase
      endcase
    end
  endfunction

  function automatic logic [AW-1:0] exp_poll(input int op, input logic [AW-1:0] a);
    if (op == 1) return a & ~22'h7FF;
    if (op == 2) return a & ~22'h7FFF;
    return a;
  endfunction

  function automatic int exp_reads();
    for (int i = 3; i < 400; i++)
      if (b6_at(i) == b6_at(i-1) && b6_at(i) == b6_at(i-2) && b6_at(i) == b6_at(i-3))
        return i + 1;
    return -1;
  endfunction

  task automatic issue(input int op, input logic [AW-1:0] a, input logic [15:0] d,
                       output logic e);
    int cyc;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    e = err;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9 ready after done / R8 pulse",
        {req_ready, done}, 2'b10);
  endtask

  task automatic run_ok(input int op, input logic [AW-1:0] a, input logic [15:0] d);
    logic e;
    logic [AW-1:0] ea;
    logic [15:0] ed;
    int bad, nexp, er;
    er = exp_reads();
    issue(op, a, d, e);
    nexp = (op == 0) ? 4 : 6;
    chk(wr_cnt == nexp, (op == 0) ? "R1 write count" : "R2 write count", wr_cnt, nexp);
    bad = 0;
    for (int i = 0; i < nexp && i < 16; i++) begin
      exp_wr(op, i, a, d, ea, ed);
      if (wa[i] !== ea || wd[i] !== ed) begin
        bad++;
        $display("FAIL %s: step %0d actual %0h/%0h expected %0h/%0h",
                 (op == 0) ? "R1" : "R2", i, wa[i], wd[i], ea, ed);
      end
    end
    chk(bad == 0, (op == 0) ? "R1 write sequence" : "R2 write sequence", bad, 0);
    chk(e == 1'b0, "R8 err low on success", e, 0);
    chk(rd_cnt == er, "R5 polling read count", rd_cnt, er);
    chk(last_rd_addr == exp_poll(op, a), "R4 poll address", last_rd_addr, exp_poll(op, a));
  endtask

  task automatic run_tmo(input int op, input logic [AW-1:0] a, input int lim);
    logic e;
    int nexp;
    time el;
    mode = 2;
    issue(op, a, 16'h0BAD, e);
    nexp = ((op == 0) ? 4 : 6) + 1;
    chk(e == 1'b1, "R7 err on timeout", e, 1);
    chk(wr_cnt == nexp, "R7 single reset write", wr_cnt, nexp);
    chk(wa[nexp-1] == '0 && wd[nexp-1] == 16'h00F0, "R7 reset write content",
        {wa[nexp-1], wd[nexp-1]}, {22'h0, 16'h00F0});
    el = (wt[nexp-1] - wt[nexp-2]) / 20;
    chk(el >= lim && el <= lim + 30, "R6 timeout window", el, lim);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic e;
    int bad;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    chk({ce_n, we_n, oe_n, dq_oe, req_ready, done} == 6'b111010, "R10 reset state",
        {ce_n, we_n, oe_n, dq_oe, req_ready, done}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every opcode over three busy lengths
    for (int op = 0; op < 4; op++)
      for (int j = 0; j < 3; j++) begin
        mode = 0;
        kpar = (j == 0) ? 0 : (j == 1) ? 3 : 8;
        run_ok(op, AW'(32'h1A5C3 + op * 32'h41111 + j * 32'h333), 16'h1234 + 16'(op * 7 + j));
      end

    // toggle during confirmation restarts the count
    mode = 1; kpar = 2; run_ok(0, 22'h0ABCD, 16'hBEEF);
    mode = 1; kpar = 3; run_ok(1, 22'h2F0F0, 16'h0000);
    mode = 1; kpar = 3; run_ok(3, 22'h00777, 16'h0000);

    // timeouts per operation class
    run_tmo(0, 22'h01234, TOP);
    run_tmo(2, 22'h1C000, TOE);
    run_tmo(3, 22'h00000, TOC);

    // requests while busy are ignored
    mode = 0; kpar = 10;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 22'h0; req_data = 16'h0;
    @(negedge clk);
    req_op = 2'd0; req_addr = 22'h3FFFF; req_data = 16'h5555;
    bad = 0;
    for (int c = 0; c < 30; c++) begin
      if (req_ready) bad++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(bad == 0, "R9 ready low while busy", bad, 0);
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    e = err;
    repeat (20) @(negedge clk);
    chk(wr_cnt == 6 && e == 1'b0, "R9 busy request ignored", wr_cnt, 6);

    chk(low_min == WL * 20 && low_max == WL * 20, "R3 write-enable low width",
        low_min, WL * 20);
    chk(high_min >= WH * 20, "R3 write-enable high width", high_min, WH * 20);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule